// File: doc/BRIEF.md
# Serial PCM Output Formatter

This block turns a stream of stereo audio samples into a three-wire serial audio link: a bit clock, a left/right word clock and one serial data line. It runs from a master clock and derives the bit clock from it with a programmable divider. Samples arrive as left/right pairs of up to 24 bits through a ready/valid handshake. One pair fills one output frame. When no pair is waiting at a frame boundary, the frame carries zeros, so the link never stops.

An 8-bit layout word selects the following:
- the sample precision and, through it, the slot length;
- which bit-clock edge the receiver samples on;
- whether the word clock leads the data by one bit;
- the word-clock polarity;
- left or right alignment inside the slot;
- MSB-first or LSB-first bit order.

The layout word and the divider are captured once, at the moment the `run` input takes the block out of its wait state. After that they are held until `run` is dropped and raised again.

Top module: `pcm_serial_out`

## Requirements
- R1: While `run` is low, and after reset, `bclk`, `wclk`, `sdata` and `s_ready` are all 0.
- R2: `fmt_cfg` and `div_cfg` are captured in the first cycle that `run` is seen high after being low. Later changes to them have no effect on the outputs until `run` goes low and then high again.
- R3: With a divider value d > 0, each bit lasts 2·(d+1) master clocks. `fmt_cfg[2]` picks the receiver's sampling edge: 0 = falling edge of `bclk` (data changes on the rising edge), 1 = rising edge (data changes on the falling edge).
- R4: With d = 0, `bclk` is the master clock itself (inverted when `fmt_cfg[2]` = 1), and one bit is sent per master clock.
- R5: `fmt_cfg[1:0]` sets the precision W: 00 = 16, 01 = 18, 10 = 20, 11 = 24. The W-bit sample sits in bits [W-1:0] of `s_left` and `s_right`, and any higher bits are ignored. A slot is 16 bit clocks when W = 16 and 32 otherwise. A frame is a left slot followed by a right slot.
- R6: `fmt_cfg[4]` sets word-clock polarity: 0 means `wclk` low marks the left channel, 1 means `wclk` high marks it.
- R7: `fmt_cfg[3]` sets framing: 0 means `wclk` switches one bit before the first bit of a slot, 1 means `wclk` switches together with it.
- R8: `fmt_cfg[5]` sets alignment: 1 puts the sample in the first W bits of its slot, 0 puts it in the last W bits. All other slot positions are 0.
- R9: `fmt_cfg[6]` sets bit order: 1 sends the MSB first, 0 sends the LSB first.
- R10: A one-entry holding stage accepts a pair when `s_valid` and `s_ready` are both high. `s_ready` is high in run whenever that stage is empty. A held pair is played in the next frame that starts after it was accepted. The first frame after a start is silent.
- R11: A frame that begins with no held pair sends all zeros on `sdata`. The word clock keeps running.
- R12: `sdata` stays constant for the whole of each bit period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | High to leave the wait state and stream frames |
| fmt_cfg | input | 8 | Serial layout word, captured on start |
| div_cfg | input | DIV_W | Bit-clock divider value, captured on start |
| s_valid | input | 1 | Sample pair offered |
| s_left | input | SMP_W | Left sample, right-justified |
| s_right | input | SMP_W | Right sample, right-justified |
| s_ready | output | 1 | Holding stage empty, pair will be taken |
| bclk | output | 1 | Serial bit clock |
| wclk | output | 1 | Left/right word clock |
| sdata | output | 1 | Serial audio data |

## Verification
The bench captures every bit at the receiver's sampling edge and compares whole frames against an independent model of the layout word.

- The divider corner case d = 0 is covered. A design that kept dividing there would produce a bit clock at half the master rate.
- The one-bit framing offset is checked. A design that got it wrong would move the word-clock change into the wrong bit.
- Right alignment is checked in 32-bit slots. A wrong design would shift samples or leave stale upper bits in the padding.
- Underrun frames are checked for zeros. A wrong design would repeat the last sample.
- The layout word and divider are changed while streaming. A design that did not latch them would change its format in the middle of a stream.

// File: rtl/pcm_fmt_pkg.sv
package pcm_fmt_pkg;

    localparam int SLOT_NARROW = 16;
    localparam int SLOT_WIDE   = 32;

    // Layout word; the bit positions are fixed by the register definition.
    typedef struct packed {
        logic       spare;      // [7]
        logic       msb_first;  // [6]
        logic       left_just;  // [5]
        logic       left_high;  // [4]
        logic       no_delay;   // [3]
        logic       samp_rise;  // [2]
        logic [1:0] prec;       // [1:0]
    } fmt_t;

    function automatic int prec_width(input logic [1:0] p);
        case (p)
            2'b00:   return 16;
            2'b01:   return 18;
            2'b10:   return 20;
            default: return 24;
        endcase
    endfunction

    function automatic int slot_len(input logic [1:0] p);
        return (p == 2'b00) ? SLOT_NARROW : SLOT_WIDE;
    endfunction

endpackage

// File: rtl/pcm_bclk_gen.sv
module pcm_bclk_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             phase,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             ph;
    } bg_t;

    bg_t bg_d, bg_q;

    always_comb begin
        bg_d = bg_q;
        if (!en) begin
            bg_d = '0;
        end else if (div != '0) begin
            if (bg_q.cnt == div) begin
                bg_d.cnt = '0;
                bg_d.ph  = ~bg_q.ph;
            end else begin
                bg_d.cnt = bg_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bg_q <= '0;
        else        bg_q <= bg_d;
    end

    // Last master clock of a bit: every clock in bypass, else end of the high phase.
    assign tick  = en & ((div == '0) | ((bg_q.cnt == div) & bg_q.ph));
    assign phase = bg_q.ph;

endmodule

// File: rtl/pcm_frame_ctr.sv
module pcm_frame_ctr #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             tick,
    input  logic             wide,
    output logic [CNT_W-1:0] bit_pos,
    output logic             wrap
);
    typedef struct packed {
        logic [CNT_W-1:0] pos;
    } fc_t;

    fc_t         fc_d, fc_q;
    logic [CNT_W-1:0] last_pos;
    logic        at_last;

    always_comb begin
        last_pos = wide ? CNT_W'(2 * pcm_fmt_pkg::SLOT_WIDE - 1)
                        : CNT_W'(2 * pcm_fmt_pkg::SLOT_NARROW - 1);
        at_last  = (fc_q.pos == last_pos);
        fc_d     = fc_q;
        if (!en)       fc_d.pos = '0;
        else if (tick) fc_d.pos = at_last ? '0 : fc_q.pos + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fc_q <= '0;
        else        fc_q <= fc_d;
    end

    assign bit_pos = fc_q.pos;
    assign wrap    = en & tick & at_last;

endmodule

// File: rtl/pcm_smp_hold.sv
module pcm_smp_hold #(
    parameter int SMP_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             take,
    input  logic             s_valid,
    input  logic [SMP_W-1:0] s_left,
    input  logic [SMP_W-1:0] s_right,
    output logic             s_ready,
    output logic [SMP_W-1:0] cur_left,
    output logic [SMP_W-1:0] cur_right
);
    typedef struct packed {
        logic             full;
        logic [SMP_W-1:0] hold_l;
        logic [SMP_W-1:0] hold_r;
        logic [SMP_W-1:0] play_l;
        logic [SMP_W-1:0] play_r;
    } sh_t;

    sh_t  sh_d, sh_q;
    logic accept;

    always_comb begin
        accept = en & ~sh_q.full & s_valid;
        sh_d   = sh_q;
        if (!en) begin
            sh_d = '0;
        end else begin
            if (take) begin
                // Frame boundary: play the held pair, or silence if none.
                sh_d.play_l = sh_q.full ? sh_q.hold_l : '0;
                sh_d.play_r = sh_q.full ? sh_q.hold_r : '0;
                sh_d.full   = 1'b0;
            end
            if (accept) begin
                sh_d.hold_l = s_left;
                sh_d.hold_r = s_right;
                sh_d.full   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign s_ready   = en & ~sh_q.full;
    assign cur_left  = sh_q.play_l;
    assign cur_right = sh_q.play_r;

endmodule

// File: rtl/pcm_serial_out.sv
module pcm_serial_out #(
    parameter int SMP_W = 24,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [7:0]       fmt_cfg,
    input  logic [DIV_W-1:0] div_cfg,
    input  logic             s_valid,
    input  logic [SMP_W-1:0] s_left,
    input  logic [SMP_W-1:0] s_right,
    output logic             s_ready,
    output logic             bclk,
    output logic             wclk,
    output logic             sdata
);
    import pcm_fmt_pkg::*;

    localparam int FRAME_MAX = 2 * SLOT_WIDE;
    localparam int CNT_W     = $clog2(FRAME_MAX);
    localparam int IDX_W     = $clog2(SMP_W);

    typedef struct packed {
        logic             act;
        fmt_t             fmt;
        logic [DIV_W-1:0] div;
    } ctl_t;

    ctl_t             ctl_d, ctl_q;
    logic             ph, tick, wrap;
    logic [CNT_W-1:0] bit_pos;
    logic [SMP_W-1:0] cur_l, cur_r;

    // Wait state / start capture
    always_comb begin
        ctl_d = ctl_q;
        if (!run) begin
            ctl_d.act = 1'b0;
        end else if (!ctl_q.act) begin
            ctl_d.act = 1'b1;
            ctl_d.fmt = fmt_t'(fmt_cfg);
            ctl_d.div = div_cfg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    pcm_bclk_gen #(.DIV_W(DIV_W)) u_bclk (
        .clk(clk), .rst_n(rst_n), .en(ctl_q.act), .div(ctl_q.div),
        .phase(ph), .tick(tick)
    );

    pcm_frame_ctr #(.CNT_W(CNT_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .en(ctl_q.act), .tick(tick),
        .wide(ctl_q.fmt.prec != 2'b00), .bit_pos(bit_pos), .wrap(wrap)
    );

    pcm_smp_hold #(.SMP_W(SMP_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .en(ctl_q.act), .take(wrap),
        .s_valid(s_valid), .s_left(s_left), .s_right(s_right),
        .s_ready(s_ready), .cur_left(cur_l), .cur_right(cur_r)
    );

    // Slot decode from the bit position
    int               wid, slot, pos, nxt, off, lead, k;
    logic             ch_data, ch_word, in_win, bit_v;
    logic [IDX_W-1:0] idx;
    logic [SMP_W-1:0] smp;

    always_comb begin
        wid     = prec_width(ctl_q.fmt.prec);
        slot    = slot_len(ctl_q.fmt.prec);
        pos     = int'(bit_pos);
        nxt     = (pos == 2 * slot - 1) ? 0 : pos + 1;
        ch_data = (pos >= slot);
        ch_word = ctl_q.fmt.no_delay ? ch_data : (nxt >= slot);
        off     = ch_data ? pos - slot : pos;
        lead    = ctl_q.fmt.left_just ? 0 : slot - wid;
        in_win  = (off >= lead) && (off < lead + wid);
        k       = off - lead;
        idx     = IDX_W'(ctl_q.fmt.msb_first ? wid - 1 - k : k);
        smp     = ch_data ? cur_r : cur_l;
        bit_v   = in_win ? smp[idx] : 1'b0;
    end

    assign bclk  = ctl_q.act & ((ctl_q.div == '0) ? (clk ^ ctl_q.fmt.samp_rise)
                                                   : ~(ph ^ ctl_q.fmt.samp_rise));
    assign wclk  = ctl_q.act & (ch_word ^ ctl_q.fmt.left_high);
    assign sdata = ctl_q.act & bit_v;

    // Observation points for the bound checker
    logic             act_w;
    logic [7:0]       fmt_w;
    logic [DIV_W-1:0] div_w;
    assign act_w = ctl_q.act;
    assign fmt_w = ctl_q.fmt;
    assign div_w = ctl_q.div;

endmodule

// File: rtl/pcm_serial_out_chk.sv
module pcm_serial_out_chk #(
    parameter int DIV_W = 8,
    parameter int CNT_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             act,
    input logic             bclk,
    input logic             wclk,
    input logic             sdata,
    input logic             s_valid,
    input logic             s_ready,
    input logic [7:0]       fmt,
    input logic [DIV_W-1:0] div,
    input logic [CNT_W-1:0] bit_pos
);
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !act |-> (!bclk && !wclk && !sdata && !s_ready));

    a_r2_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (act && $past(act)) |-> ($stable(fmt) && $stable(div)));

    a_r10_one_deep: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_ready) |=> !s_ready);

    a_r12_bit_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (act && $past(act) && $stable(bit_pos)) |-> $stable(sdata));
endmodule

bind pcm_serial_out pcm_serial_out_chk #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .act(act_w), .bclk(bclk), .wclk(wclk),
    .sdata(sdata), .s_valid(s_valid), .s_ready(s_ready),
    .fmt(fmt_w), .div(div_w), .bit_pos(bit_pos)
);

// File: tb/sim_pcm_serial_out.sv
`timescale 1ns/1ps
module sim_pcm_serial_out;
    logic        clk = 1'b0;
    logic        rst_n, run, s_valid, s_ready, bclk, wclk, sdata;
    logic [7:0]  fmt_cfg, div_cfg;
    logic [23:0] s_left, s_right;

    always #10 clk = ~clk;   // 50 MHz

    pcm_serial_out u0 (
        .clk(clk), .rst_n(rst_n), .run(run), .fmt_cfg(fmt_cfg), .div_cfg(div_cfg),
        .s_valid(s_valid), .s_left(s_left), .s_right(s_right), .s_ready(s_ready),
        .bclk(bclk), .wclk(wclk), .sdata(sdata)
    );

    int n_chk = 0, n_bad = 0, cyc = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    // Receiver model: one capture per bit at the sampling edge (R12: bit held steady)
    bit cap_d[256], cap_w[256];
    int cap_t[256];
    int cap_n;
    bit cap_en, cap_byp, cap_lvl, prev_b;

    always @(negedge clk) begin
        if (cap_en && cap_n < 256) begin
            if (cap_byp || (bclk != prev_b && bclk == cap_lvl)) begin
                cap_d[cap_n] = sdata;
                cap_w[cap_n] = wclk;
                cap_t[cap_n] = cyc;
                cap_n++;
            end
        end
        prev_b = bclk;
    end

    // Sample source
    logic [23:0] fl[4], fr[4];
    int feed_n, feed_i;
    bit pend;

    always @(negedge clk) begin
        if (pend) feed_i++;
        if (cap_en && feed_i < feed_n) begin
            s_valid = 1'b1; s_left = fl[feed_i]; s_right = fr[feed_i];
        end else begin
            s_valid = 1'b0;
        end
        pend = s_valid && s_ready;
    end

    // Expected serial bit and word clock, from the requirements
    function automatic void model(input logic [7:0] f, input int bc,
                                  input logic [23:0] l, input logic [23:0] r,
                                  output bit w, output bit d);
        int sw = (f[1:0] == 2'b00) ? 16 : 32;
        int wd = (f[1:0] == 2'b00) ? 16 : (f[1:0] == 2'b01) ? 18 : (f[1:0] == 2'b10) ? 20 : 24;
        bit right_half = (bc >= sw);
        int nb = (bc + 1) % (2 * sw);
        bit word_right = f[3] ? right_half : (nb >= sw);
        int p = bc % sw;
        int st = f[5] ? 0 : sw - wd;
        logic [23:0] s = right_half ? r : l;
        w = word_right ^ f[4];
        d = 1'b0;
        if (p >= st && p < st + wd) d = f[6] ? s[wd - 1 - (p - st)] : s[p - st];
    endfunction

    task automatic run_case(input logic [7:0] f, input logic [7:0] dv, input int ns,
                            input int nf, input bit poke, input string tg);
        int sw = (f[1:0] == 2'b00) ? 16 : 32;
        int total = nf * 2 * sw;
        @(negedge clk);
        run = 1'b0; cap_en = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk(!bclk && !wclk && !sdata && !s_ready, {tg, " R1 idle outputs"},
            {bclk, wclk, sdata, s_ready}, 0);
        fmt_cfg = f; div_cfg = dv; feed_n = ns; feed_i = 0; pend = 1'b0; cap_n = 0;
        cap_byp = (dv == 0); cap_lvl = f[2]; prev_b = bclk;
        run = 1'b1;
        @(posedge clk); #1;
        cap_en = 1'b1;
        if (poke) begin   // R2: must have no effect
            fmt_cfg = ~f; div_cfg = dv + 8'd3;
        end
        chk(s_ready == 1'b1, {tg, " R10 ready after start"}, s_ready, 1);
        if (cap_byp) begin
            chk(bclk == (1'b1 ^ f[2]), {tg, " R4 bclk high phase"}, bclk, 1 ^ f[2]);
            @(negedge clk); #1;
            chk(bclk == f[2], {tg, " R4 bclk low phase"}, bclk, f[2]);
        end
        while (cap_n < total) @(negedge clk);
        for (int fi = 0; fi < nf; fi++) begin
            int bad_d = 0, bad_w = 0;
            logic [23:0] l = (fi >= 1 && fi <= ns) ? fl[fi - 1] : 24'h0;
            logic [23:0] r = (fi >= 1 && fi <= ns) ? fr[fi - 1] : 24'h0;
            for (int b = 0; b < 2 * sw; b++) begin
                bit ew, ed;
                model(f, b, l, r, ew, ed);
                if (cap_d[fi * 2 * sw + b] != ed) bad_d++;
                if (cap_w[fi * 2 * sw + b] != ew) bad_w++;
            end
            chk(bad_d == 0, $sformatf("%s R5 R8 R9 R10 R11 data frame %0d mismatches", tg, fi), bad_d, 0);
            chk(bad_w == 0, $sformatf("%s R6 R7 wclk frame %0d mismatches", tg, fi), bad_w, 0);
        end
        if (cap_byp)
            chk(cap_t[1] - cap_t[0] == 1, {tg, " R4 clocks per bit"}, cap_t[1] - cap_t[0], 1);
        else
            chk(cap_t[1] - cap_t[0] == 2 * (dv + 1), {tg, " R3 clocks per bit"},
                cap_t[1] - cap_t[0], 2 * (dv + 1));
        @(negedge clk);
        run = 1'b0; cap_en = 1'b0;
    endtask

    initial begin
        rst_n = 1'b0; run = 1'b0; s_valid = 1'b0; s_left = '0; s_right = '0;
        fmt_cfg = '0; div_cfg = '0; cap_en = 1'b0; cap_n = 0; feed_n = 0; feed_i = 0;
        pend = 1'b0;
        for (int i = 0; i < 4; i++) begin
            fl[i] = 24'h9E37B5 ^ (24'(i + 1) * 24'h013579);
            fr[i] = 24'h5A1C63 + (24'(i + 1) * 24'h02468A);
        end
        repeat (4) @(negedge clk);
        #1;
        chk(!bclk && !wclk && !sdata && !s_ready, "R1 reset outputs", {bclk, wclk, sdata, s_ready}, 0);
        rst_n = 1'b1;
        // 16-bit, I2S delay, low=left, left aligned, MSB first; config poked mid-run (R2)
        run_case(8'h60, 8'd1, 2, 4, 1'b1, "caseA R2");
        // 24-bit, rising-edge sampling, no delay, high=left, right aligned, LSB first
        run_case(8'h1F, 8'd2, 3, 4, 1'b0, "caseB");
        // 18-bit, I2S delay, high=left, left aligned, MSB first, bypass divider
        run_case(8'h71, 8'd0, 2, 3, 1'b0, "caseC");
        // 20-bit, no delay, low=left, right aligned, MSB first
        run_case(8'h4A, 8'd3, 1, 3, 1'b0, "caseD");
        // bypass divider with rising-edge sampling, 16-bit LSB first right aligned
        run_case(8'h04, 8'd0, 1, 2, 1'b0, "caseE");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule